// File: doc/BRIEF.md
# Stereo Logarithmic Attenuator With Mute

This block scales a stream of signed stereo PCM sample pairs. Each channel has its own control word. The word carries a 6-bit attenuation code, which selects a gain from 0 dB down to -63 dB in exact 1 dB steps. It also carries a mute bit that silences that channel alone. A separate external mute input silences both channels at once. The block sits in the sample-rate domain, between a control-word receiver and the interpolation filter. Neither of those neighbours is part of it.

Each pair arrives with a valid strobe. On that strobe the block captures the two samples, both control words and the external mute input. It looks up a Q1.15 linear gain of 10^(-n/20) for each channel, multiplies, rounds to nearest and keeps the input width. Muted channels are forced to zero. The scaled pair comes out two clock cycles later with its own valid strobe.

Top module: `stereo_log_atten`

## Requirements
- R1: A control word is 7 bits wide. Bit 6 is the channel's mute bit and bits 5:0 are its attenuation code. With code 0, no mute bit set and external mute low, the output sample equals the input sample exactly.
- R2: For code n, the gain coefficient is g(n) = round(32768 * 10^(-n/20)), an unsigned Q1.15 value. The output is floor((x * g(n) + 16384) / 32768), kept at 16 bits signed.
- R3: Code 63, the largest, applies -63 dB, which is a coefficient of 23. Code 1 applies -1 dB, which is a coefficient of 29205.
- R4: With external mute high when a pair is captured, both output samples of that pair are exactly zero, whatever the codes.
- R5: A channel's mute bit set when a pair is captured forces only that channel's output to zero. The other channel is scaled normally.
- R6: `out_valid` is high for exactly one cycle, two clock cycles after each cycle in which `in_valid` is high. Back-to-back inputs give back-to-back outputs.
- R7: Control words and external mute are sampled only in the cycle where `in_valid` is high. Both channels of a pair use settings from that same cycle. Changes while `in_valid` is low have no effect on any output.
- R8: Between valid outputs, `out_left` and `out_right` hold the last produced values.
- R9: While `rst_n` is low at a clock edge, both outputs go to zero and `out_valid` goes low.
- R10: The magnitude of an output never exceeds the magnitude of its input. An input of -32768 at code 0 stays -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| ctl_left | input | 7 | Left control word: bit 6 mute, bits 5:0 attenuation code |
| ctl_right | input | 7 | Right control word: bit 6 mute, bits 5:0 attenuation code |
| ext_mute | input | 1 | Mutes both channels when high |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
The properties assume that `rst_n` is held low for at least two edges before the first `in_valid`. They also assume that the control and mute inputs are settled in every cycle where `in_valid` is high. The driver changes all inputs only on the falling clock edge and always holds reset for several cycles before it starts. In every idle cycle it scrambles the control words and external mute, so the sample-once rule is tested continuously rather than only in a dedicated case.

// File: rtl/atten_pkg.sv
// Shared constants and the gain-table generator for the stereo attenuator.
// Assumes the coefficient function is called only at elaboration time.
package atten_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_CODE_W   = 6;
    localparam int DEF_COEF_W   = 16;

    // Linear gain 10^(-n/20) scaled by 2^frac and rounded to nearest.
    function automatic int unsigned gain_coef(input int n, input int frac);
        real g;
        g = 10.0 ** (-real'(n) / 20.0);
        return int'($rtoi(g * (2.0 ** frac) + 0.5));
    endfunction

endpackage

// File: rtl/atten_gain_rom.sv
// Combinational dB-to-linear lookup: code n selects round(2^(COEF_W-1)*10^(-n/20)).
// Assumes COEF_W-1 fraction bits, so unity gain fits as 1 << (COEF_W-1).
module atten_gain_rom #(
    parameter int CODE_W = atten_pkg::DEF_CODE_W,
    parameter int COEF_W = atten_pkg::DEF_COEF_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [COEF_W-1:0] coef
);
    localparam int DEPTH = 1 << CODE_W;
    localparam int FRAC  = COEF_W - 1;

    logic [COEF_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [COEF_W-1:0] ENTRY = COEF_W'(atten_pkg::gain_coef(i, FRAC));
        assign table_q[i] = ENTRY;
    end

    // Select the coefficient for the requested code.
    always_comb coef = table_q[code];

endmodule

// File: rtl/atten_scale.sv
// Signed-by-unsigned multiply with round-half-up and truncation back to SAMPLE_W.
// Assumes coef <= 1.0 in Q1.(COEF_W-1), so the result never needs saturation.
module atten_scale #(
    parameter int SAMPLE_W = atten_pkg::DEF_SAMPLE_W,
    parameter int COEF_W   = atten_pkg::DEF_COEF_W
) (
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic        [COEF_W-1:0]   coef,
    output logic signed [SAMPLE_W-1:0] y
);
    localparam int PW   = SAMPLE_W + COEF_W + 1;
    localparam int FRAC = COEF_W - 1;

    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] cs;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    // Widen, multiply, add half an LSB and drop the fraction bits.
    always_comb begin
        xs   = PW'(x);
        cs   = PW'(signed'({1'b0, coef}));
        prod = xs * cs;
        rnd  = prod + (PW'(1) <<< (FRAC - 1));
        y    = SAMPLE_W'(rnd >>> FRAC);
    end

endmodule

// File: rtl/atten_chan.sv
// One channel: stage 1 captures sample, coefficient and mute on in_valid;
// stage 2 scales, forces zero when muted and holds the result.
// Assumes the top drives s1_valid one cycle after in_valid.
module atten_chan #(
    parameter int SAMPLE_W = atten_pkg::DEF_SAMPLE_W,
    parameter int CODE_W   = atten_pkg::DEF_CODE_W,
    parameter int COEF_W   = atten_pkg::DEF_COEF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       s1_valid,
    input  logic signed [SAMPLE_W-1:0] in_smp,
    input  logic        [CODE_W-1:0]   in_code,
    input  logic                       in_mute,
    output logic signed [SAMPLE_W-1:0] out_smp
);
    logic        [COEF_W-1:0]   coef_c;
    logic signed [SAMPLE_W-1:0] s1_smp;
    logic        [COEF_W-1:0]   s1_coef;
    logic                       s1_mute;
    logic signed [SAMPLE_W-1:0] scaled_c;

    atten_gain_rom #(.CODE_W(CODE_W), .COEF_W(COEF_W)) u_rom (
        .code (in_code),
        .coef (coef_c)
    );

    // Capture the sample and its settings once per input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_smp  <= '0;
            s1_coef <= '0;
            s1_mute <= 1'b0;
        end else if (in_valid) begin
            s1_smp  <= in_smp;
            s1_coef <= coef_c;
            s1_mute <= in_mute;
        end
    end

    atten_scale #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_scale (
        .x    (s1_smp),
        .coef (s1_coef),
        .y    (scaled_c)
    );

    // Register the scaled or muted result; hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_smp <= '0;
        else if (s1_valid) out_smp <= s1_mute ? '0 : scaled_c;
    end

    function automatic logic [SAMPLE_W:0] mag(input logic signed [SAMPLE_W-1:0] v);
        return v[SAMPLE_W-1] ? (SAMPLE_W+1)'(-$signed({v[SAMPLE_W-1], v})) : {1'b0, v};
    endfunction

    // R10: attenuation never grows the magnitude of a sample.
    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (mag(out_smp) <= mag($past(s1_smp))));

    // R5: a captured mute yields exactly zero on the next result.
    a_r5_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mute) |=> (out_smp == '0));

endmodule

// File: rtl/stereo_log_atten.sv
// Stereo attenuator top: per-channel 1 dB step gain with per-channel and global mute.
// Two-cycle pipeline; settings sampled together with each sample pair.
// Assumes synchronous active-low reset, held for at least two edges.
module stereo_log_atten #(
    parameter int SAMPLE_W = atten_pkg::DEF_SAMPLE_W,
    parameter int CODE_W   = atten_pkg::DEF_CODE_W,
    parameter int COEF_W   = atten_pkg::DEF_COEF_W,
    localparam int CTL_W   = CODE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic        [CTL_W-1:0]    ctl_left,
    input  logic        [CTL_W-1:0]    ctl_right,
    input  logic                       ext_mute,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);
    localparam int NCH    = 2;
    localparam int MUTE_B = CODE_W;

    logic                       s1_valid;
    logic signed [SAMPLE_W-1:0] smp_in  [NCH];
    logic        [CTL_W-1:0]    ctl_in  [NCH];
    logic signed [SAMPLE_W-1:0] smp_out [NCH];

    // Gather both channels into arrays for the channel generate.
    always_comb begin
        smp_in[0] = in_left;
        smp_in[1] = in_right;
        ctl_in[0] = ctl_left;
        ctl_in[1] = ctl_right;
    end

    // Strobe pipeline matching the two data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        atten_chan #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .COEF_W(COEF_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .s1_valid (s1_valid),
            .in_smp   (smp_in[c]),
            .in_code  (ctl_in[c][CODE_W-1:0]),
            .in_mute  (ctl_in[c][MUTE_B] | ext_mute),
            .out_smp  (smp_out[c])
        );
    end

    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

    // R6: every strobe in comes out exactly two cycles later.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R4: the external mute clears both channels of the captured pair.
    a_r4_global_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_mute) |=> ##1 (out_left == '0 && out_right == '0));

    // R1: code 0 unmuted passes the left sample through unchanged.
    a_r1_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_mute && ctl_left == '0) |=> ##1 (out_left == $past(in_left, 2)));

    // R8: with no strobe in stage 1, outputs hold their values.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_left) && $stable(out_right)));

endmodule

// File: tb/sim_stereo_log_atten.sv
module sim_stereo_log_atten;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_left = '0;
    logic signed [15:0] in_right = '0;
    logic [6:0]        ctl_left = '0;
    logic [6:0]        ctl_right = '0;
    logic              ext_mute = 1'b0;
    logic              out_valid;
    logic signed [15:0] out_left;
    logic signed [15:0] out_right;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int exp_l_q[$];
    int exp_r_q[$];
    int exp_c_q[$];
    logic signed [15:0] last_l = '0;
    logic signed [15:0] last_r = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stereo_log_atten u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .ctl_left(ctl_left), .ctl_right(ctl_right), .ext_mute(ext_mute),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic int coef_of(input int n);
        return $rtoi(32768.0 * (10.0 ** (-real'(n) / 20.0)) + 0.5);
    endfunction

    function automatic int expect_of(input int x, input int code, input bit mute);
        longint p;
        if (mute) return 0;
        p = longint'(x) * longint'(coef_of(code)) + 64'sd16384;
        return int'(p >>> 15);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one pair per call, held for one cycle; pushes expected results.
    task automatic send(input int l, input int r, input bit [6:0] cl,
                        input bit [6:0] cr, input bit em);
        @(negedge clk);
        in_valid  = 1'b1;
        in_left   = 16'(l);
        in_right  = 16'(r);
        ctl_left  = cl;
        ctl_right = cr;
        ext_mute  = em;
        exp_l_q.push_back(expect_of(l, int'(cl[5:0]), cl[6] | em));
        exp_r_q.push_back(expect_of(r, int'(cr[5:0]), cr[6] | em));
        exp_c_q.push_back(cyc);
    endtask

    // Idle cycles scramble settings; R7 says they must not matter.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            ctl_left  = 7'($urandom);
            ctl_right = 7'($urandom);
            ext_mute  = 1'($urandom);
            in_left   = 16'($urandom);
            in_right  = 16'($urandom);
        end
    endtask

    // Monitor: pop and compare each result; check hold between results.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_l_q.size() == 0) begin
                    check("R6 unexpected out_valid", 1, 0);
                end else begin
                    int el, er, ec;
                    el = exp_l_q.pop_front();
                    er = exp_r_q.pop_front();
                    ec = exp_c_q.pop_front();
                    check("R2 left value", int'(out_left), el);
                    check("R2 right value", int'(out_right), er);
                    check("R6 latency", cyc - ec, 2);
                end
                last_l <= out_left;
                last_r <= out_right;
            end else begin
                check("R8 hold left", int'(out_left), int'(last_l));
                check("R8 hold right", int'(out_right), int'(last_r));
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        finish_run();
    end

    initial begin
        // R9: reset state after several edges with input activity.
        in_valid = 1'b1;
        in_left  = 16'sd1000;
        repeat (4) @(negedge clk);
        check("R9 reset out_valid", int'(out_valid), 0);
        check("R9 reset left", int'(out_left), 0);
        check("R9 reset right", int'(out_right), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(3);

        // R1: code 0 unmuted is a pass-through, including full-scale negative (R10).
        send(1234, -5678, 7'd0, 7'd0, 1'b0);
        send(-32768, 32767, 7'd0, 7'd0, 1'b0);
        idle(3);

        // R3: explicit boundary coefficients.
        check("R3 code 63 coef", coef_of(63), 23);
        check("R3 code 1 coef", coef_of(1), 29205);
        send(32767, -32768, 7'd63, 7'd63, 1'b0);
        send(32767, -32768, 7'd1, 7'd1, 1'b0);
        idle(2);

        // R2: sweep all codes on full-scale inputs, opposite codes per channel.
        for (int n = 0; n < 64; n++) begin
            send(32767, -32768, 7'(n), 7'(63 - n), 1'b0);
            idle(n % 3);
        end
        idle(3);

        // R2/R10: random samples and codes, back-to-back (R6).
        for (int k = 0; k < 200; k++) begin
            send(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 {1'b0, 6'($urandom)}, {1'b0, 6'($urandom)}, 1'b0);
        end
        idle(3);

        // R4: global mute zeroes both channels whatever the codes.
        send(20000, -20000, 7'd0, 7'd5, 1'b1);
        send(-1, 1, 7'd63, 7'd0, 1'b1);
        // R5: per-channel mute affects only its own channel.
        send(15000, 15000, 7'h40, 7'd0, 1'b0);
        send(15000, -15000, 7'd3, 7'h4A, 1'b0);
        idle(1);
        // R7: pair after scrambled idles uses only its own settings.
        send(-9000, 9000, 7'd6, 7'd6, 1'b0);
        idle(5);
        // R8: several idle cycles follow with scrambled inputs; monitor checks hold.
        idle(10);

        check("R6 all results produced", exp_l_q.size(), 0);
        finish_run();
    end

endmodule